// File: doc/BRIEF.md
# Register Undo Log with Serial Rewind

This block keeps the working register file of a pipeline that writes results at completion time, together with an undo log that can put that file back to an earlier point in program order. Each decoded instruction takes the next free log slot and receives a tag. When the instruction completes, the block writes its result into the register file. In that same cycle the value being overwritten is saved into the instruction's slot. Retirement frees slots at the oldest end. The log is read only during recovery, so the register file always holds the latest, possibly speculative, values.

Two events start a recovery. The first is a faulting oldest instruction presented for retirement. The second is a mispredicted branch, named by its tag. In both cases the controller walks the log backward from the youngest slot, one slot per cycle. Every completed slot writes its saved value back into the register file. A slot that never completed is dropped without a write. The walk ends at the head for a fault, or just after the branch's slot for a misprediction. `busy` is high for the whole walk.

The controller is a two-state machine. The states are HB_IDLE, where allocation, completion and retirement are served, and HB_UNWIND, where one slot is undone per cycle. It has three transitions. T_FAULT takes HB_IDLE to HB_UNWIND when the oldest slot is completed, flagged as faulting and asked to retire. T_FLUSH takes HB_IDLE to HB_UNWIND when a mispredict names a live slot that has at least one younger slot. T_DONE takes HB_UNWIND back to HB_IDLE after the last step.

Top module: `hb_undo_log`

## Requirements
- R1: Out of reset, and while not busy, `dec_valid` with the log not full takes the slot shown on `dec_tag`. `dec_tag` then advances by one, modulo DEPTH. `occupancy` counts the live slots.
- R2: `log_full` is high when `occupancy` equals DEPTH. An allocation in that state is refused: `dec_tag` and `occupancy` stay unchanged by it.
- R3: `done_valid` on a live, not yet completed tag writes `done_data` into that slot's destination register, visible on `rd_data` from the next cycle. The previous value is saved in the slot. A completion on a dead or already completed tag changes nothing.
- R4: `retire_req` frees the oldest slot only if it is completed and not faulting. `retire_ack` is high in that same cycle. An uncompleted oldest slot stays.
- R5: `mp_valid` with a live `mp_tag` removes every younger slot, youngest first, one per cycle. Completed slots restore their saved value. `busy` stays high for exactly as many cycles as there were younger slots. Afterwards `dec_tag` equals `mp_tag` plus one.
- R6: `retire_req` on a completed oldest slot whose `done_exc` flag was set raises `fault_valid` for one cycle, with that slot's PC on `fault_pc`. It then unwinds all live slots, including the faulting one. `busy` lasts `occupancy` cycles, and `dec_tag` returns to the old head.
- R7: A slot that was allocated but never completed still uses its unwind cycle but writes no register.
- R8: While `busy` is high, every decode, completion, retire and mispredict input is ignored. In the cycle a recovery is accepted, all other inputs are ignored too, and a fault takes priority over a mispredict.
- R9: After reset all registers read zero, `occupancy` is zero, `busy`, `fault_valid` and `log_full` are low, and `dec_tag` is zero.
- R10: Allocation, completion and retirement can act in the same cycle. A completion of the oldest slot in the cycle it is asked to retire does not retire it in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Allocate a slot for a decoded instruction |
| dec_dest | input | REG_W | Destination register of the new instruction |
| dec_pc | input | PC_W | PC of the new instruction |
| dec_tag | output | IDX_W | Slot the next allocation receives |
| log_full | output | 1 | All DEPTH slots live |
| done_valid | input | 1 | Completion of the instruction named by done_tag |
| done_tag | input | IDX_W | Slot of the completing instruction |
| done_data | input | DATA_W | Result written to the register file |
| done_exc | input | 1 | Completing instruction faulted |
| retire_req | input | 1 | Try to retire the oldest slot |
| retire_ack | output | 1 | Oldest slot freed this cycle |
| mp_valid | input | 1 | Branch misprediction resolved |
| mp_tag | input | IDX_W | Slot of the mispredicted branch |
| busy | output | 1 | Unwind in progress |
| fault_valid | output | 1 | One-cycle pulse: fault recovery started |
| fault_pc | output | PC_W | PC of the faulting instruction |
| occupancy | output | IDX_W+1 | Number of live slots |
| rd_addr | input | REG_W | Register file read address |
| rd_data | output | DATA_W | Register file read data |

## Verification
Completion and retirement can meet in one cycle, and so can a recovery request and any other request. The bench provokes these collisions deliberately. It completes the oldest slot while asking to retire it, allocates into a full log while retiring, and offers a mispredict together with a faulting retire. It then keeps driving every input while the unwind runs. A queue-based model applies the stated priorities to each clock edge. Each cycle the model's register contents, occupancy, tag, busy and fault outputs are compared with the ports, so a collision resolved the wrong way shows up as a miscompare at the cycle it happens or at a later register read.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [0:0] {
        HB_IDLE   = 1'b0,
        HB_UNWIND = 1'b1
    } hb_state_e;
endpackage

// File: rtl/hb_regfile.sv
module hb_regfile #(
    parameter int NREG   = 8,
    parameter int DATA_W = 16,
    parameter int REG_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [REG_W-1:0]  old_addr,
    output logic [DATA_W-1:0] old_data,
    input  logic              we,
    input  logic [REG_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata
);
    logic [DATA_W-1:0] regs_q [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (we) begin
            regs_q[waddr] <= wdata;
        end
    end

    assign rd_data  = regs_q[rd_addr];
    assign old_data = regs_q[old_addr];
endmodule

// File: rtl/hb_entries.sv
module hb_entries #(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 3,
    parameter int DATA_W = 16,
    parameter int PC_W   = 16,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              al_go,
    input  logic [IDX_W-1:0]  al_idx,
    input  logic [REG_W-1:0]  al_dest,
    input  logic [PC_W-1:0]   al_pc,
    input  logic              cap_go,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic [DATA_W-1:0] cap_old,
    input  logic              cap_exc,
    input  logic              clr_go,
    input  logic [IDX_W-1:0]  clr_idx,
    output logic [DEPTH-1:0]  e_valid,
    output logic [DEPTH-1:0]  e_done,
    output logic [DEPTH-1:0]  e_exc,
    output logic [REG_W-1:0]  e_dest [DEPTH],
    output logic [DATA_W-1:0] e_old  [DEPTH],
    output logic [PC_W-1:0]   e_pc   [DEPTH]
);
    // Slot-local storage: each slot only listens to commands carrying its index.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_valid[s] <= 1'b0;
                e_done[s]  <= 1'b0;
                e_exc[s]   <= 1'b0;
                e_dest[s]  <= '0;
                e_old[s]   <= '0;
                e_pc[s]    <= '0;
            end else begin
                if (clr_go && clr_idx == IDX_W'(s)) begin
                    e_valid[s] <= 1'b0;
                    e_done[s]  <= 1'b0;
                end
                if (al_go && al_idx == IDX_W'(s)) begin
                    e_valid[s] <= 1'b1;
                    e_done[s]  <= 1'b0;
                    e_exc[s]   <= 1'b0;
                    e_dest[s]  <= al_dest;
                    e_pc[s]    <= al_pc;
                end
                if (cap_go && cap_idx == IDX_W'(s)) begin
                    e_done[s] <= 1'b1;
                    e_exc[s]  <= cap_exc;
                    e_old[s]  <= cap_old;
                end
            end
        end
    end
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
    import hb_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 3,
    parameter int DATA_W = 16,
    parameter int PC_W   = 16,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    input  logic              done_valid,
    input  logic [IDX_W-1:0]  done_tag,
    input  logic [DATA_W-1:0] done_data,
    input  logic              retire_req,
    input  logic              mp_valid,
    input  logic [IDX_W-1:0]  mp_tag,
    input  logic [DEPTH-1:0]  e_valid,
    input  logic [DEPTH-1:0]  e_done,
    input  logic [DEPTH-1:0]  e_exc,
    input  logic [REG_W-1:0]  e_dest [DEPTH],
    input  logic [DATA_W-1:0] e_old  [DEPTH],
    input  logic [PC_W-1:0]   e_pc   [DEPTH],
    output logic              al_go,
    output logic [IDX_W-1:0]  tail,
    output logic              cap_go,
    output logic [REG_W-1:0]  cap_addr,
    output logic              clr_go,
    output logic [IDX_W-1:0]  clr_idx,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              busy,
    output logic              retire_ack,
    output logic              log_full,
    output logic [IDX_W:0]    occupancy,
    output logic              fault_valid,
    output logic [PC_W-1:0]   fault_pc
);
    localparam int CNT_W = IDX_W + 1;

    hb_state_e          state_q, state_d;
    logic [IDX_W-1:0]   head_q, tail_q, cur_q;
    logic [CNT_W-1:0]   count_q, rem_q;
    logic               fault_q;
    logic [PC_W-1:0]    fault_pc_q;

    logic               idle, empty, fault_go, ret_go, mp_ok, mp_go, recov;
    logic [IDX_W-1:0]   mp_steps;

    // Request decoding, all from the state at the start of the cycle.
    always_comb begin
        idle     = (state_q == HB_IDLE);
        empty    = (count_q == '0);
        fault_go = idle && retire_req && !empty && e_done[head_q] && e_exc[head_q];
        mp_ok    = idle && !fault_go && mp_valid && e_valid[mp_tag];
        mp_steps = tail_q - mp_tag - IDX_W'(1);
        mp_go    = mp_ok && (mp_steps != '0);
        recov    = fault_go || mp_ok;
        ret_go   = idle && !recov && retire_req && !empty && e_done[head_q] && !e_exc[head_q];
        al_go    = idle && !recov && dec_valid && (count_q != CNT_W'(DEPTH));
        cap_go   = idle && !recov && done_valid && e_valid[done_tag] && !e_done[done_tag];
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HB_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: T_FAULT, T_FLUSH, T_DONE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HB_IDLE:   if (fault_go || mp_go) state_d = HB_UNWIND;
            HB_UNWIND: if (rem_q == CNT_W'(1)) state_d = HB_IDLE;
        endcase
    end

    // Pointers, counters and the fault report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q     <= '0;
            tail_q     <= '0;
            cur_q      <= '0;
            count_q    <= '0;
            rem_q      <= '0;
            fault_q    <= 1'b0;
            fault_pc_q <= '0;
        end else begin
            fault_q <= 1'b0;
            unique case (state_q)
                HB_IDLE: begin
                    if (fault_go) begin
                        cur_q      <= tail_q - IDX_W'(1);
                        rem_q      <= count_q;
                        fault_q    <= 1'b1;
                        fault_pc_q <= e_pc[head_q];
                    end else if (mp_go) begin
                        cur_q <= tail_q - IDX_W'(1);
                        rem_q <= CNT_W'(mp_steps);
                    end else if (!mp_ok) begin
                        head_q  <= head_q + IDX_W'(ret_go);
                        tail_q  <= tail_q + IDX_W'(al_go);
                        count_q <= count_q + CNT_W'(al_go) - CNT_W'(ret_go);
                    end
                end
                HB_UNWIND: begin
                    cur_q   <= cur_q - IDX_W'(1);
                    tail_q  <= tail_q - IDX_W'(1);
                    count_q <= count_q - CNT_W'(1);
                    rem_q   <= rem_q - CNT_W'(1);
                end
            endcase
        end
    end

    // Outputs and datapath steering.
    always_comb begin
        busy        = (state_q == HB_UNWIND);
        tail        = tail_q;
        occupancy   = count_q;
        log_full    = (count_q == CNT_W'(DEPTH));
        retire_ack  = ret_go;
        fault_valid = fault_q;
        fault_pc    = fault_pc_q;
        cap_addr    = e_dest[done_tag];
        clr_go      = ret_go || busy;
        clr_idx     = busy ? cur_q : head_q;
        if (cap_go) begin
            rf_we    = 1'b1;
            rf_waddr = e_dest[done_tag];
            rf_wdata = done_data;
        end else begin
            rf_we    = busy && e_done[cur_q];
            rf_waddr = e_dest[cur_q];
            rf_wdata = e_old[cur_q];
        end
    end
endmodule

// File: rtl/hb_undo_log.sv
module hb_undo_log #(
    parameter int NREG   = 8,
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int PC_W   = 16,
    parameter int REG_W  = $clog2(NREG),
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    input  logic [REG_W-1:0]  dec_dest,
    input  logic [PC_W-1:0]   dec_pc,
    output logic [IDX_W-1:0]  dec_tag,
    output logic              log_full,
    input  logic              done_valid,
    input  logic [IDX_W-1:0]  done_tag,
    input  logic [DATA_W-1:0] done_data,
    input  logic              done_exc,
    input  logic              retire_req,
    output logic              retire_ack,
    input  logic              mp_valid,
    input  logic [IDX_W-1:0]  mp_tag,
    output logic              busy,
    output logic              fault_valid,
    output logic [PC_W-1:0]   fault_pc,
    output logic [IDX_W:0]    occupancy,
    input  logic [REG_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic              al_go, cap_go, clr_go, rf_we;
    logic [IDX_W-1:0]  clr_idx;
    logic [REG_W-1:0]  cap_addr, rf_waddr;
    logic [DATA_W-1:0] rf_wdata, old_data;
    logic [DEPTH-1:0]  e_valid, e_done, e_exc;
    logic [REG_W-1:0]  e_dest [DEPTH];
    logic [DATA_W-1:0] e_old  [DEPTH];
    logic [PC_W-1:0]   e_pc   [DEPTH];

    hb_regfile #(.NREG(NREG), .DATA_W(DATA_W), .REG_W(REG_W)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .old_addr(cap_addr), .old_data(old_data),
        .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata)
    );

    hb_entries #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .PC_W(PC_W), .IDX_W(IDX_W)) u_log (
        .clk(clk), .rst_n(rst_n),
        .al_go(al_go), .al_idx(dec_tag), .al_dest(dec_dest), .al_pc(dec_pc),
        .cap_go(cap_go), .cap_idx(done_tag), .cap_old(old_data), .cap_exc(done_exc),
        .clr_go(clr_go), .clr_idx(clr_idx),
        .e_valid(e_valid), .e_done(e_done), .e_exc(e_exc),
        .e_dest(e_dest), .e_old(e_old), .e_pc(e_pc)
    );

    hb_ctrl #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .PC_W(PC_W), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .done_valid(done_valid), .done_tag(done_tag),
        .done_data(done_data), .retire_req(retire_req),
        .mp_valid(mp_valid), .mp_tag(mp_tag),
        .e_valid(e_valid), .e_done(e_done), .e_exc(e_exc),
        .e_dest(e_dest), .e_old(e_old), .e_pc(e_pc),
        .al_go(al_go), .tail(dec_tag), .cap_go(cap_go), .cap_addr(cap_addr),
        .clr_go(clr_go), .clr_idx(clr_idx),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .busy(busy), .retire_ack(retire_ack), .log_full(log_full),
        .occupancy(occupancy), .fault_valid(fault_valid), .fault_pc(fault_pc)
    );
endmodule

// File: rtl/hb_undo_log_chk.sv
module hb_undo_log_chk #(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             log_full,
    input logic             retire_ack,
    input logic             fault_valid,
    input logic [IDX_W-1:0] dec_tag,
    input logic [IDX_W:0]   occupancy
);
    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= (IDX_W+1)'(DEPTH)); // R1

    AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (log_full && !busy) |=> occupancy <= $past(occupancy)); // R2

    AST_RETIRE_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        retire_ack |=> occupancy <= $past(occupancy)); // R4

    AST_UNWIND_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> occupancy == $past(occupancy) - (IDX_W+1)'(1)); // R5

    AST_FAULT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> busy); // R6

    AST_UNWIND_TAG_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> dec_tag == $past(dec_tag) - IDX_W'(1)); // R8
endmodule

bind hb_undo_log hb_undo_log_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .log_full(log_full),
    .retire_ack(retire_ack), .fault_valid(fault_valid),
    .dec_tag(dec_tag), .occupancy(occupancy)
);

// File: tb/hb_undo_log_tb_top.sv
module hb_undo_log_tb_top;
    localparam int NREG = 8, DEPTH = 8, DATA_W = 16, PC_W = 16;
    localparam int REG_W = $clog2(NREG), IDX_W = $clog2(DEPTH);

    logic clk = 1'b0, rst_n = 1'b0;
    logic dec_valid, done_valid, done_exc, retire_req, mp_valid;
    logic [REG_W-1:0] dec_dest, rd_addr;
    logic [PC_W-1:0] dec_pc, fault_pc;
    logic [IDX_W-1:0] dec_tag, done_tag, mp_tag;
    logic [DATA_W-1:0] done_data, rd_data;
    logic log_full, retire_ack, busy, fault_valid;
    logic [IDX_W:0] occupancy;

    always #2.5 clk = ~clk;

    hb_undo_log #(.NREG(NREG), .DEPTH(DEPTH), .DATA_W(DATA_W), .PC_W(PC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_dest(dec_dest), .dec_pc(dec_pc),
        .dec_tag(dec_tag), .log_full(log_full), .done_valid(done_valid), .done_tag(done_tag),
        .done_data(done_data), .done_exc(done_exc), .retire_req(retire_req),
        .retire_ack(retire_ack), .mp_valid(mp_valid), .mp_tag(mp_tag), .busy(busy),
        .fault_valid(fault_valid), .fault_pc(fault_pc), .occupancy(occupancy),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    typedef struct { int tag; int dest; int pc; bit done; bit exc; int old; } rec_t;
    rec_t q[$];
    int rf [NREG];
    int m_tail = 0, m_target = 0, m_fpc = 0;
    bit m_busy = 0, m_fault = 0;
    int vectors = 0, miscompares = 0, cyc_n = 0;
    bit finished = 0;

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc_n);
        end
    endtask

    function automatic int find_tag(int t);
        for (int i = 0; i < q.size(); i++) if (q[i].tag == t) return i;
        return -1;
    endfunction

    function automatic bit m_fault_go();
        return !m_busy && retire_req && q.size() > 0 && q[0].done && q[0].exc;
    endfunction

    function automatic bit m_mp_ok();
        return !m_busy && !m_fault_go() && mp_valid && find_tag(int'(mp_tag)) >= 0;
    endfunction

    function automatic bit m_ret_go();
        return !m_busy && !m_fault_go() && !m_mp_ok() && retire_req &&
               q.size() > 0 && q[0].done && !q[0].exc;
    endfunction

    // Model of one clock edge, written from the requirements.
    task automatic model_edge();
        bit fg, mo, rg;
        int sz0;
        fg = m_fault_go(); mo = m_mp_ok(); rg = m_ret_go();
        sz0 = q.size();
        m_fault = 0;
        if (m_busy) begin
            rec_t r;
            r = q.pop_back();
            if (r.done) rf[r.dest] = r.old;          // R5 restore, R7 skip
            m_tail = (m_tail + DEPTH - 1) % DEPTH;
            if (q.size() == m_target) m_busy = 0;
        end else if (fg) begin                        // R6
            m_fault = 1; m_fpc = q[0].pc; m_target = 0; m_busy = 1;
        end else if (mo) begin                        // R5, R8 priority
            m_target = find_tag(int'(mp_tag)) + 1;
            m_busy = (q.size() > m_target);
        end else begin
            if (rg) void'(q.pop_front());             // R4
            if (done_valid) begin                     // R3
                int i;
                i = find_tag(int'(done_tag));
                if (i >= 0 && !q[i].done) begin
                    q[i].old = rf[q[i].dest];
                    rf[q[i].dest] = int'(done_data);
                    q[i].done = 1; q[i].exc = done_exc;
                end
            end
            if (dec_valid && sz0 < DEPTH) begin       // R1, R2
                rec_t n;
                n.tag = m_tail; n.dest = int'(dec_dest); n.pc = int'(dec_pc);
                n.done = 0; n.exc = 0; n.old = 0;
                q.push_back(n);
                m_tail = (m_tail + 1) % DEPTH;
            end
        end
    endtask

    task automatic idle_in();
        dec_valid = 0; dec_dest = '0; dec_pc = '0; done_valid = 0; done_tag = '0;
        done_data = '0; done_exc = 0; retire_req = 0; mp_valid = 0; mp_tag = '0;
    endtask

    // Inputs are set at a falling edge; checks run 1 ns later, then the edge is modelled.
    task automatic cyc();
        rd_addr = REG_W'(cyc_n % NREG);
        #1;
        chk("R1 dec_tag", int'(dec_tag), m_tail);
        chk("R1 occupancy", int'(occupancy), q.size());
        chk("R2 log_full", int'(log_full), int'(q.size() == DEPTH));
        chk("R4 retire_ack", int'(retire_ack), int'(m_ret_go()));
        chk("R8 busy", int'(busy), int'(m_busy));
        chk("R6 fault_valid", int'(fault_valid), int'(m_fault));
        if (m_fault) chk("R6 fault_pc", int'(fault_pc), m_fpc);
        chk("R3 R5 R7 rd_data", int'(rd_data), rf[int'(rd_addr)]);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cyc_n++;
    endtask

    task automatic alloc(int d, int pc);
        idle_in(); dec_valid = 1; dec_dest = REG_W'(d); dec_pc = PC_W'(pc); cyc();
    endtask
    task automatic complete(int t, int v, bit e);
        idle_in(); done_valid = 1; done_tag = IDX_W'(t); done_data = DATA_W'(v); done_exc = e; cyc();
    endtask
    task automatic retire();
        idle_in(); retire_req = 1; cyc();
    endtask
    task automatic mispredict(int t);
        idle_in(); mp_valid = 1; mp_tag = IDX_W'(t); cyc();
    endtask
    task automatic drain_busy();
        // R8: drive every input while unwinding; all must be ignored.
        while (m_busy) begin
            idle_in(); dec_valid = 1; dec_dest = 3'd5; done_valid = 1;
            done_tag = IDX_W'(cyc_n); done_data = 16'hdead; retire_req = 1;
            mp_valid = 1; mp_tag = IDX_W'(cyc_n + 1); cyc();
        end
    endtask
    task automatic sweep_regs();
        for (int k = 0; k < NREG; k++) begin idle_in(); cyc(); end
    endtask
    task automatic empty_log();
        for (int k = 0; k < 3 * DEPTH && q.size() > 0; k++) begin
            if (!q[0].done) complete(q[0].tag, 16'h0100 + k, 0);
            else retire();
        end
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) rf[i] = 0;
        idle_in(); rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R9 reset state across all registers
        sweep_regs();

        // R1 R3 R4: in-order alloc, out-of-order completion, in-order retire
        alloc(1, 100); alloc(2, 104); alloc(1, 108); alloc(3, 112);
        complete(2, 16'h1111, 0); complete(0, 16'h2222, 0);
        complete(3, 16'h3333, 0); complete(1, 16'h4444, 0);
        complete(1, 16'h9999, 0);           // R3 already completed: ignored
        complete(6, 16'h7777, 0);           // R3 dead tag: ignored
        sweep_regs();
        repeat (4) retire();
        retire();                            // R4 empty: no ack

        // R4 R10: uncompleted head not retired; completion with retire same cycle
        alloc(4, 200); retire();
        idle_in(); retire_req = 1; done_valid = 1; done_tag = IDX_W'(q[0].tag);
        done_data = 16'h0abc; dec_valid = 1; dec_dest = 3'd6; dec_pc = 16'd204; cyc();
        idle_in(); retire_req = 1; done_valid = 1; done_tag = IDX_W'(q[0].tag + 1);
        done_data = 16'h0def; cyc();         // R10 retire + completion together
        empty_log();

        // R2: fill, refused alloc, alloc with retire when full
        for (int k = 0; k < DEPTH + 2; k++) alloc(k % 3, 300 + 4 * k);
        complete(q[0].tag, 16'h0a0a, 0);
        idle_in(); retire_req = 1; dec_valid = 1; dec_dest = 3'd7; cyc();
        // R5 R7: several writes to one register, some uncompleted, then flush
        for (int k = 1; k < DEPTH; k += 2) complete(q[k].tag, 16'h5000 + k, 0);
        sweep_regs();
        mispredict(q[1].tag);
        drain_busy();
        sweep_regs();
        // zero-step mispredict on the youngest
        mispredict(q[q.size() - 1].tag);
        alloc(2, 400);
        empty_log();

        // R6 R8: fault at head, with a mispredict in the same cycle
        alloc(1, 500); alloc(1, 504); alloc(2, 508); alloc(1, 512);
        complete(q[1].tag, 16'h6001, 0); complete(q[0].tag, 16'h6000, 1);
        complete(q[3].tag, 16'h6003, 0);
        idle_in(); retire_req = 1; mp_valid = 1; mp_tag = IDX_W'(q[2].tag); cyc();
        drain_busy();
        sweep_regs();

        // Mixed random traffic across all functions
        for (int k = 0; k < 4000; k++) begin
            idle_in();
            dec_valid = ($urandom % 3) != 0; dec_dest = REG_W'($urandom);
            dec_pc = PC_W'($urandom);
            done_valid = ($urandom % 2) != 0; done_tag = IDX_W'($urandom);
            done_data = DATA_W'($urandom); done_exc = ($urandom % 16) == 0;
            retire_req = ($urandom % 3) == 0;
            mp_valid = ($urandom % 24) == 0; mp_tag = IDX_W'($urandom);
            cyc();
        end
        idle_in();
        while (m_busy) cyc();
        sweep_regs();

        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #(100000 * 5);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule